// File: doc/BRIEF.md
# Rate-Retimed Sequential Divider

This block divides one 16-bit unsigned number by another and looks to the slower logic around it like a divider that answers in a single cycle. Underneath, it is a small bit-serial restoring divider. It runs on a fast clock that ticks twenty times for each slow-rate cycle. A slow-rate strobe is high for one fast cycle in every twenty. On that cycle the block takes in a new dividend and divisor. It then works out the quotient and remainder over the next fast cycles, and moves them to its outputs only at the end of the following strobe cycle. Seen from the slow domain, an operation issued in one slow cycle has its answer in the next one.

By default the strobe comes from a counter inside the block that counts modulo the clock ratio. A parameter can select an external strobe input instead. The strobe that is actually in use is driven out on `strobe_o`, so the slow-rate logic can align to it. When the divisor is zero, the block returns a defined result and raises a flag.

Top module: `osdiv_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `quotient_o`, `remainder_o` and `div_zero_o` are all zero. The internal strobe counter restarts on reset, so `strobe_o` is first high in the cycle that follows 19 rising edges after reset is released, and not before.
- R2: For a divisor other than zero, the outputs become `quotient_o` = dividend / divisor and `remainder_o` = dividend mod divisor. They take these values at the clock edge that ends the strobe cycle after the one in which the operands were sampled.
- R3: The three outputs change only at a clock edge that ends a strobe cycle. At every other edge they hold their values.
- R4: Operand inputs are sampled only at the edge that ends a strobe cycle. Values they carry between strobes have no effect on any result.
- R5: When the divisor is zero, the result is `quotient_o` = 16'hFFFF, `remainder_o` = dividend and `div_zero_o` = 1. For any divisor other than zero, `div_zero_o` = 0.
- R6: With the internal strobe selected (default), `strobe_o` is high for exactly one cycle in every 20 cycles.
- R7: A new operation is accepted on every strobe with no idle slot. The core is never busy when a strobe arrives, so back-to-back operations all return correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (ratio times the slow rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_strobe_i | input | 1 | External slow-rate strobe, used only when the internal counter is disabled |
| dividend_i | input | 16 | Unsigned dividend, sampled on a strobe cycle |
| divisor_i | input | 16 | Unsigned divisor, sampled on a strobe cycle |
| strobe_o | output | 1 | Strobe in use, high one cycle per slow period |
| quotient_o | output | 16 | Registered quotient of the previous operation |
| remainder_o | output | 16 | Registered remainder of the previous operation |
| div_zero_o | output | 1 | Previous operation had a zero divisor |

## Verification
A wrong step count or a wrong quotient-bit decision in the iterating core produces a bad quotient or remainder. That error reaches the ports exactly one strobe after the operands went in. The bench compares every result in the cycle right after that strobe edge. Faults in the output hold register or in the strobe counter show up within a single fast cycle: an output moves between strobes, or the strobe arrives at the wrong spacing. These are checked on every fast cycle. Operands are scrambled between strobes, so a core that samples outside the strobe cycle returns a wrong result on the next strobe.

// File: rtl/osdiv_pkg.sv
// Shared types for the rate-retimed divider.
package osdiv_pkg;
    // Core sequencer: waiting, iterating one bit per cycle, publishing result.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } div_state_t;
endpackage

// File: rtl/osdiv_strobe_gen.sv
// Slow-rate strobe source. With USE_INT set, a modulo-RATIO counter makes a
// one-cycle pulse every RATIO fast cycles; otherwise the external strobe is
// passed through. Assumes RATIO >= 2.
module osdiv_strobe_gen #(
    parameter int RATIO   = 20,
    parameter bit USE_INT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_strobe_i,
    output logic strobe_o
);
    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;

    generate
        if (USE_INT) begin : g_int
            logic [CW-1:0] cnt;
            logic          unused_ext;
            assign unused_ext = ext_strobe_i;

            // Count fast cycles modulo RATIO; reset restarts the period.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt <= '0;
                else if (cnt == CW'(RATIO - 1))
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end

            assign strobe_o = (cnt == CW'(RATIO - 1));

            // R6: the strobe never lasts two cycles in a row.
            a_r6_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
                strobe_o |=> !strobe_o);
        end else begin : g_ext
            assign strobe_o = ext_strobe_i;
        end
    endgenerate
endmodule

// File: rtl/osdiv_core.sv
// Bit-serial restoring divider. It loads operands on start_i, produces one
// quotient bit per cycle for W cycles, then publishes the result in a
// finish cycle (W+2 cycles in all). Assumes start_i only arrives while idle.
// A zero divisor forces an all-ones quotient and returns the dividend.
module osdiv_core
    import osdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic [W-1:0] res_q_o,
    output logic [W-1:0] res_r_o,
    output logic         res_z_o
);
    localparam int SW = $clog2(W + 1);

    div_state_t    state;
    logic [SW-1:0] step;
    logic [W-1:0]  q_sh, rem, dvs, dvd_keep;
    logic          zero;

    logic [W:0]    rem_ext, diff;
    logic [W-1:0]  q_next, rem_next;

    // One restoring step: shift in the next dividend bit, try to subtract.
    always_comb begin
        rem_ext = {rem, q_sh[W-1]};
        diff    = rem_ext - {1'b0, dvs};
        if (!diff[W]) begin
            rem_next = diff[W-1:0];
            q_next   = {q_sh[W-2:0], 1'b1};
        end else begin
            rem_next = rem_ext[W-1:0];
            q_next   = {q_sh[W-2:0], 1'b0};
        end
    end

    // Sequencer and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step     <= '0;
            q_sh     <= '0;
            rem      <= '0;
            dvs      <= '0;
            dvd_keep <= '0;
            zero     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start_i) begin
                    q_sh     <= dividend_i;
                    dvd_keep <= dividend_i;
                    dvs      <= divisor_i;
                    rem      <= '0;
                    zero     <= (divisor_i == '0);
                    step     <= SW'(W);
                    state    <= ST_RUN;
                end
                ST_RUN: begin
                    q_sh  <= q_next;
                    rem   <= rem_next;
                    step  <= step - 1'b1;
                    if (step == SW'(1))
                        state <= ST_FINISH;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result registers, written once per operation in the finish cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q_o <= '0;
            res_r_o <= '0;
            res_z_o <= 1'b0;
        end else if (state == ST_FINISH) begin
            res_q_o <= zero ? {W{1'b1}} : q_sh;
            res_r_o <= zero ? dvd_keep : rem;
            res_z_o <= zero;
        end
    end

    assign busy_o = (state != ST_IDLE);

    // R2: a finished non-zero division leaves a remainder below the divisor.
    a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && !zero) |-> (rem < dvs));

    // R5: iterating with a zero divisor naturally yields all ones and the dividend.
    a_r5_zero_iteration: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && zero) |-> (q_sh == {W{1'b1}} && rem == dvd_keep));
endmodule

// File: rtl/osdiv_out_hold.sv
// Output retiming stage: copies the core result to the ports only at the
// edge that ends a strobe cycle, so outputs move at the slow rate alone.
module osdiv_out_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] q_i,
    input  logic [W-1:0] r_i,
    input  logic         z_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] r_o,
    output logic         z_o
);
    // Capture the finished result on the strobe edge; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
            r_o <= '0;
            z_o <= 1'b0;
        end else if (load_i) begin
            q_o <= q_i;
            r_o <= r_i;
            z_o <= z_i;
        end
    end

    // R3: outside strobe edges nothing at the outputs moves.
    a_r3_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(q_o) && $stable(r_o) && $stable(z_o)));

    // R5: the zero flag always comes with an all-ones quotient.
    a_r5_flag_with_ones: assert property (@(posedge clk) disable iff (!rst_n)
        z_o |-> (q_o == {W{1'b1}}));
endmodule

// File: rtl/osdiv_top.sv
// Rate-retimed unsigned divider. Each strobe samples new operands into the
// iterating core and publishes the previous operation's result. Assumes
// RATIO >= W + 2, so that a division ends before the next strobe.
module osdiv_top #(
    parameter int W       = 16,
    parameter int RATIO   = 20,
    parameter bit USE_INT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ext_strobe_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         strobe_o,
    output logic [W-1:0] quotient_o,
    output logic [W-1:0] remainder_o,
    output logic         div_zero_o
);
    logic         strobe, busy, res_z;
    logic [W-1:0] res_q, res_r;

    osdiv_strobe_gen #(.RATIO(RATIO), .USE_INT(USE_INT)) u_strobe (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_strobe_i (ext_strobe_i),
        .strobe_o     (strobe)
    );

    osdiv_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (strobe),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .busy_o     (busy),
        .res_q_o    (res_q),
        .res_r_o    (res_r),
        .res_z_o    (res_z)
    );

    osdiv_out_hold #(.W(W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (strobe),
        .q_i    (res_q),
        .r_i    (res_r),
        .z_i    (res_z),
        .q_o    (quotient_o),
        .r_o    (remainder_o),
        .z_o    (div_zero_o)
    );

    assign strobe_o = strobe;

    // R7: the core has always finished when the next strobe arrives.
    a_r7_idle_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !busy);
endmodule

// File: tb/sim_osdiv_top.sv
// Bench: directed corner operands followed by seeded random ones. Each
// result is compared one strobe later; outputs and strobe spacing are
// checked on every fast cycle in between.
module sim_osdiv_top;
    localparam int CLK_P = 10;
    localparam int W     = 16;
    localparam int RATIO = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ext_strobe = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         strobe;
    logic [W-1:0] q_out, r_out;
    logic         z_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit pend = 1'b0;
    logic [W-1:0] pa, pb;

    osdiv_top #(.W(W), .RATIO(RATIO), .USE_INT(1'b1)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_strobe_i (ext_strobe),
        .dividend_i   (a_in),
        .divisor_i    (b_in),
        .strobe_o     (strobe),
        .quotient_o   (q_out),
        .remainder_o  (r_out),
        .div_zero_o   (z_out)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [W-1:0] ref_q(input logic [W-1:0] a, input logic [W-1:0] b);
        return (b == '0) ? {W{1'b1}} : a / b;
    endfunction

    function automatic logic [W-1:0] ref_r(input logic [W-1:0] a, input logic [W-1:0] b);
        return (b == '0) ? a : a % b;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue one operation at a strobe negedge; check the previous result,
    // then scramble inputs and watch outputs and strobe until the next strobe.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] sq, sr;
        logic         sz;
        a_in = a;
        b_in = b;
        @(negedge clk);
        if (pend) begin
            if (pb == '0) begin
                check(q_out == 16'hFFFF, "R5", "zero-divisor quotient", q_out, 16'hFFFF);
                check(r_out == pa, "R5", "zero-divisor remainder", r_out, pa);
                check(z_out == 1'b1, "R5", "zero flag set", z_out, 1);
            end else begin
                check(q_out == ref_q(pa, pb), "R2 R4 R7", "quotient", q_out, ref_q(pa, pb));
                check(r_out == ref_r(pa, pb), "R2 R4 R7", "remainder", r_out, ref_r(pa, pb));
                check(z_out == 1'b0, "R5", "zero flag clear", z_out, 0);
            end
        end
        sq = q_out; sr = r_out; sz = z_out;
        pend = 1'b1; pa = a; pb = b;
        for (int i = 1; i < RATIO; i++) begin
            a_in = W'($urandom);
            b_in = W'($urandom);
            @(negedge clk);
            check(q_out == sq && r_out == sr && z_out == sz, "R3", "outputs held",
                  {q_out, r_out}, {sq, sr});
            check(strobe == (i == RATIO - 1), "R6", "strobe spacing", strobe, (i == RATIO - 1));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(q_out == '0 && r_out == '0, "R1", "outputs in reset", {q_out, r_out}, 0);
        check(z_out == 1'b0, "R1", "flag in reset", z_out, 0);
        rst_n = 1'b1;
        check(q_out == '0 && r_out == '0 && !z_out, "R1", "outputs after release", {q_out, r_out}, 0);
        for (int n = 1; n < RATIO; n++) begin
            @(negedge clk);
            check(strobe == (n == RATIO - 1), "R1", "first strobe timing", strobe, (n == RATIO - 1));
        end
        run_op(16'h0000, 16'h0001);
        run_op(16'hFFFF, 16'h0001);
        run_op(16'hFFFF, 16'hFFFF);
        run_op(16'h0001, 16'hFFFF);
        run_op(16'h1234, 16'h0000);
        run_op(16'h0000, 16'h0000);
        run_op(16'h8000, 16'h0003);
        run_op(16'hFFFF, 16'hFFFE);
        run_op(16'h00FF, 16'h0010);
        run_op(16'hABCD, 16'h0000);
        for (int k = 0; k < 60; k++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = (k % 4 == 0) ? W'($urandom % 16) : W'($urandom);
            run_op(ra, rb);
        end
        run_op(16'h0007, 16'h0002);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog run did not complete actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule